// File: doc/BRIEF.md
# Keyboard Matrix Column Driver

This block turns a column-drive request into the signals that a keyboard scan matrix needs. A request asks for every column, for none, or for one column given by index. The block then produces two outputs: a select word for the scan controller, and the level of one dedicated line. That dedicated line serves column 2, which is wired outside the controller's own column pins and has inverted polarity.

Selecting column 2 therefore turns the controller's column outputs off and raises the dedicated line. Every other single column is driven through the controller, with the dedicated line held low. Both outputs come from registers and change together on the clock edge after a request is accepted. Between requests they hold their values.

The rows have pull-ups. The controller's columns are open-drain, and the dedicated column-2 line is push-pull. Reading rows, debouncing and decoding keys are handled elsewhere.

Top module: `kbd_col_drive`

## Requirements
- R1: After reset, the select word is 8'h40 (scan outputs disabled) and the column-2 line is low.
- R2: An accepted request of kind 2'b01 (all columns) makes the select word 8'h20 on the next clock edge, with only bit 5 set and bit 6 clear, and drives the column-2 line high.
- R3: An accepted request of kind 2'b00 or 2'b11 (no columns) makes the select word 8'h40 on the next clock edge, with only bit 6 set, and drives the column-2 line low.
- R4: An accepted request of kind 2'b10 (one column) with index 2 makes the select word 8'h40 on the next clock edge and drives the column-2 line high.
- R5: An accepted one-column request with an index below NUM_COLS other than 2 places that index in bits 4:0 of the select word, with bits 7:5 clear, and drives the column-2 line low, on the next clock edge.
- R6: A one-column request whose index is NUM_COLS (default 13) or above is handled as a no-columns request: the select word becomes 8'h40 and the column-2 line goes low.
- R7: While req_valid is low, the select word and the column-2 line keep their values.
- R8: The select word and the column-2 line change on the same clock edge. The column-2 line is never high while bits 5 and 6 of the select word are both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 00 none, 01 all, 10 one column, 11 none |
| req_col | input | IDX_W | Column index for a one-column request |
| scan_sel | output | 8 | Select word for the scan controller |
| col2_drive | output | 1 | Level of the separate, inverted column-2 line |

## Verification
The assertions take req_kind and req_col to be known values in every cycle where req_valid is high. Indices outside the column range are legal input and map to the no-columns result. The stimulus drives every input from the falling edge, so the values are stable at each rising edge. It never leaves an input undriven after reset. Across the run it covers every request kind, every index from 0 to 31, and idle gaps between requests.

// File: rtl/kbd_col_drive.sv
module kbd_col_drive #(
  parameter int NUM_COLS = 13,
  parameter int IDX_W    = 5,
  parameter int INV_COL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [IDX_W-1:0] req_col,
  output logic [7:0]       scan_sel,
  output logic             col2_drive
);
  localparam logic [7:0] SEL_ALL = 8'h20;
  localparam logic [7:0] SEL_OFF = 8'h40;

  logic       in_range;
  logic [7:0] sel_next;
  logic       c2_next;

  assign in_range = 32'(req_col) < NUM_COLS;

  always_comb begin
    sel_next = SEL_OFF;
    c2_next  = 1'b0;
    unique case (req_kind)
      2'b01: begin
        sel_next = SEL_ALL;
        c2_next  = 1'b1;
      end
      2'b10: begin
        if (in_range && 32'(req_col) == INV_COL) begin
          c2_next = 1'b1;
        end else if (in_range) begin
          sel_next = 8'(req_col) & 8'h1f;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_sel   <= SEL_OFF;
      col2_drive <= 1'b0;
    end else if (req_valid) begin
      scan_sel   <= sel_next;
      col2_drive <= c2_next;
    end
  end
endmodule

// File: rtl/kbd_col_drive_chk.sv
module kbd_col_drive_chk #(
  parameter int NUM_COLS = 13,
  parameter int IDX_W    = 5,
  parameter int INV_COL  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [IDX_W-1:0] req_col,
  input logic [7:0]       scan_sel,
  input logic             col2_drive
);
  a_r2_all_cols: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b01 |=> scan_sel == 8'h20 && col2_drive);

  a_r3_no_cols: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_kind == 2'b00 || req_kind == 2'b11) |=> scan_sel == 8'h40 && !col2_drive);

  a_r4_inv_col: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b10 && 32'(req_col) == INV_COL && INV_COL < NUM_COLS
    |=> scan_sel == 8'h40 && col2_drive);

  a_r5_single_col: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b10 && 32'(req_col) < NUM_COLS && 32'(req_col) != INV_COL
    |=> scan_sel[7:5] == 3'b000 && 32'(scan_sel[4:0]) == 32'($past(req_col)) && !col2_drive);

  a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b10 && 32'(req_col) >= NUM_COLS |=> scan_sel == 8'h40 && !col2_drive);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(scan_sel) && $stable(col2_drive));

  a_r8_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    col2_drive |-> (scan_sel[5] || scan_sel[6]));
endmodule

bind kbd_col_drive kbd_col_drive_chk #(
  .NUM_COLS(NUM_COLS), .IDX_W(IDX_W), .INV_COL(INV_COL)
) u_chk (.*);

// File: tb/tb_kbd_col_drive.sv
module tb_kbd_col_drive;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [4:0] req_col = 5'd0;
  logic [7:0] scan_sel;
  logic       col2_drive;

  int checks = 0;
  int errors = 0;
  int exp_sel = 8'h40;
  int exp_c2 = 0;
  string exp_tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbd_col_drive dut (.*);

  // Behavioural reference: whole-word results per request class
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_sel <= 8'h40; exp_c2 <= 0; exp_tag <= "R1";
    end else if (req_valid) begin
      if (req_kind == 2'b01) begin
        exp_sel <= 32; exp_c2 <= 1; exp_tag <= "R2";
      end else if (req_kind == 2'b10 && req_col >= 13) begin
        exp_sel <= 64; exp_c2 <= 0; exp_tag <= "R6";
      end else if (req_kind == 2'b10 && req_col == 2) begin
        exp_sel <= 64; exp_c2 <= 1; exp_tag <= "R4";
      end else if (req_kind == 2'b10) begin
        exp_sel <= int'(req_col); exp_c2 <= 0; exp_tag <= "R5";
      end else begin
        exp_sel <= 64; exp_c2 <= 0; exp_tag <= "R3";
      end
    end else begin
      exp_tag <= "R7";
    end
  end

  task automatic check_now();
    checks++;
    if (int'(scan_sel) != exp_sel || int'(col2_drive) != exp_c2) begin
      errors++;
      $display("FAIL %s/R8: sel=%02h c2=%0d expected sel=%02h c2=%0d",
               exp_tag, scan_sel, col2_drive, exp_sel[7:0], exp_c2);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [4:0] c);
    @(negedge clk);
    check_now();
    req_valid = v; req_kind = k; req_col = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_now();            // R1 reset state
    rst_n = 1'b1;
    step(1'b0, 2'b00, 5'd0);
    step(1'b1, 2'b01, 5'd9);   // R2
    step(1'b0, 2'b10, 5'd4);   // R7 hold
    step(1'b0, 2'b00, 5'd0);
    step(1'b1, 2'b00, 5'd3);   // R3
    step(1'b1, 2'b10, 5'd2);   // R4
    step(1'b0, 2'b01, 5'd0);   // R7
    step(1'b1, 2'b11, 5'd1);   // R3 kind 11
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 2'b10, 5'(i));   // R5, R4, R6
      step(1'b1, 2'b01, 5'(i));   // R8 alternation
    end
    step(1'b1, 2'b10, 5'd12);  // R5 top column
    step(1'b1, 2'b10, 5'd13);  // R6 boundary
    step(1'b1, 2'b10, 5'd0);
    step(1'b0, 2'b00, 5'd0);
    step(1'b0, 2'b00, 5'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule